// File: doc/BRIEF.md
# Programmable Spreading Code Generator

This block produces the chip stream that a direct-sequence despreader multiplies against the received signal. One core covers four code families: Gold codes built from two run-time programmable shift registers, maximal-length sequences from the first register alone, the 11-chip and 13-chip Barker words, and the satellite-navigation coarse-acquisition codes with a per-satellite output tap pair on the second register. The same chip is driven on the in-phase and the quadrature outputs.

Chips leave through a valid/ready stream. `chip_valid` is high from the first cycle after reset. The presented chip stays on the outputs until a cycle in which `chip_ready` is high, so the consumer sets the chip rate purely through back-pressure. The consumer may hold `chip_ready` low for any number of cycles. The programmed period, which may be shorter than the natural sequence length, restarts the sequence and reloads the registers. A one-cycle `restart` input lets an acquisition engine realign the code to the start of a period at any time. Configuration inputs are expected to be held steady while chips are drawn; a change takes effect cleanly at the next `restart`.

Top module: `spc_code_gen`

## Requirements
- R1: While `rst` is high `chip_valid` is 0; in the first cycle after `rst` falls, `chip_valid` is 1 and `sop` is 1, and `chip_valid` stays 1 until the next reset.
- R2: A polynomial mask bit j stands for the term x^(j+1) (the constant term is implied); the register order n is one more than the highest set bit, the register output is cell n, and `code_type` 2 emits register A alone (for mask 0x09 a 15-chip sequence starting 1,1,1,1,0,1,0,1,1,0,0,1,0,0,0).
- R3: A period counter wraps after `code_period` accepted chips (valid 3 to 65535); at every wrap both registers are reloaded, so a period shorter than 2^n-1 truncates the sequence and repeats its first chips.
- R4: `code_type` 1 emits the XOR of the outputs of register A and register B; register A reloads to all ones and register B to all ones XOR `gold_offset`, so a non-zero offset selects a different code of the family; the offset has no effect in any other type.
- R5: `code_type` 3 emits a Barker word MSB first: 0x5B8 (11 chips) when `code_period` is 11, otherwise 0x1F35 (13 chips); chip positions beyond the word are 0.
- R6: `code_type` 4 ignores both masks and the offset, uses 1+x^3+x^10 for register A and 1+x^2+x^3+x^6+x^8+x^9+x^10 for register B, and XORs register A's output with the XOR of two register B cells chosen by `sat_id` (1 to 37; satellite 1 gives 1,1,0,0,1,0,0,0,0,0, satellite 2 gives 1,1,1,0,0,1,0,0,0,0); for `sat_id` 0 or above 37 the register B term is 0.
- R7: The chip, `sop` and the period position advance only in a cycle with `chip_valid` and `chip_ready` high and `restart` low; otherwise they hold.
- R8: `sop` is 1 exactly while the first chip of a period is presented.
- R9: `chip_q` always equals `chip_i`.
- R10: A cycle with `restart` high reloads both registers and clears the period position; the next cycle presents the first chip of the period with `sop` high, and a handshake during the restart cycle is not counted.
- R11: `code_type` values 0, 5, 6 and 7 emit constant 0 chips while the period counter and `sop` keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Realign to the start of a period |
| code_type | input | 3 | 1 Gold, 2 maximal length, 3 Barker, 4 C/A, others silent |
| poly_a | input | 24 | Generator mask of register A |
| poly_b | input | 24 | Generator mask of register B |
| gold_offset | input | 24 | Register B start-state offset in Gold mode |
| sat_id | input | 6 | Satellite number for C/A mode |
| code_period | input | 16 | Code period in chips |
| chip_ready | input | 1 | Consumer accepts the presented chip |
| chip_valid | output | 1 | A chip is presented |
| chip_i | output | 1 | In-phase chip |
| chip_q | output | 1 | Quadrature chip (same as in-phase) |
| sop | output | 1 | First chip of a period is presented |

## Verification
The chip and `sop` are decoded without a register from the shift-register and counter state, so after the edge that ends a reset or a restart the first chip is readable in that same following cycle, and each accepted handshake moves to the next chip at exactly one clock edge. The bench changes inputs and reads outputs on the falling edge, reading chip k in the k-th falling edge after the restart with `chip_ready` held high, and holds `chip_ready` low for several cycles to show the one-edge rule is gated by the handshake. Expected words come from hand-derived sequences and, for Gold codes, from a bench model stepped chip by chip.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    CT_NONE   = 3'd0,
    CT_GOLD   = 3'd1,
    CT_MLS    = 3'd2,
    CT_BARKER = 3'd3,
    CT_CA     = 3'd4
  } code_t;

  // Navigation code polynomials, bit j = x^(j+1)
  localparam logic [9:0] CA_A_MASK = 10'h204;
  localparam logic [9:0] CA_B_MASK = 10'h3A6;

  localparam logic [10:0] BARKER11 = 11'h5B8;
  localparam logic [12:0] BARKER13 = 13'h1F35;
  localparam int          SAT_MAX  = 37;
endpackage

// File: rtl/spc_lfsr.sv
module spc_lfsr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] mask,
  output logic [W-1:0] state
);
  // state[k-1] holds cell k; new bit enters cell 1
  always_ff @(posedge clk) begin
    if (load)
      state <= seed;
    else if (step)
      state <= {state[W-2:0], ^(state & mask)};
  end
endmodule

// File: rtl/spc_tap_pick.sv
module spc_tap_pick #(
  parameter int W = 24
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] mask,
  output logic         out_bit
);
  // Output cell is the one matching the highest set mask bit
  always_comb begin
    out_bit = 1'b0;
    for (int k = 0; k < W; k++)
      if (mask[k]) out_bit = state[k];
  end
endmodule

// File: rtl/spc_sat_taps.sv
module spc_sat_taps #(
  parameter int SAT_W = 6
) (
  input  logic [SAT_W-1:0] sat,
  output logic             hit,
  output logic [3:0]       tap_a,
  output logic [3:0]       tap_b
);
  always_comb begin
    hit = 1'b1;
    unique case (int'(sat))
      1:  {tap_a, tap_b} = {4'd2, 4'd6};
      2:  {tap_a, tap_b} = {4'd3, 4'd7};
      3:  {tap_a, tap_b} = {4'd4, 4'd8};
      4:  {tap_a, tap_b} = {4'd5, 4'd9};
      5:  {tap_a, tap_b} = {4'd1, 4'd9};
      6:  {tap_a, tap_b} = {4'd2, 4'd10};
      7:  {tap_a, tap_b} = {4'd1, 4'd8};
      8:  {tap_a, tap_b} = {4'd2, 4'd9};
      9:  {tap_a, tap_b} = {4'd3, 4'd10};
      10: {tap_a, tap_b} = {4'd2, 4'd3};
      11: {tap_a, tap_b} = {4'd3, 4'd4};
      12: {tap_a, tap_b} = {4'd5, 4'd6};
      13: {tap_a, tap_b} = {4'd6, 4'd7};
      14: {tap_a, tap_b} = {4'd7, 4'd8};
      15: {tap_a, tap_b} = {4'd8, 4'd9};
      16: {tap_a, tap_b} = {4'd9, 4'd10};
      17: {tap_a, tap_b} = {4'd1, 4'd4};
      18: {tap_a, tap_b} = {4'd2, 4'd5};
      19: {tap_a, tap_b} = {4'd3, 4'd6};
      20: {tap_a, tap_b} = {4'd4, 4'd7};
      21: {tap_a, tap_b} = {4'd5, 4'd8};
      22: {tap_a, tap_b} = {4'd6, 4'd9};
      23: {tap_a, tap_b} = {4'd1, 4'd3};
      24: {tap_a, tap_b} = {4'd4, 4'd6};
      25: {tap_a, tap_b} = {4'd5, 4'd7};
      26: {tap_a, tap_b} = {4'd6, 4'd8};
      27: {tap_a, tap_b} = {4'd7, 4'd9};
      28: {tap_a, tap_b} = {4'd8, 4'd10};
      29: {tap_a, tap_b} = {4'd1, 4'd6};
      30: {tap_a, tap_b} = {4'd2, 4'd7};
      31: {tap_a, tap_b} = {4'd3, 4'd8};
      32: {tap_a, tap_b} = {4'd4, 4'd9};
      33: {tap_a, tap_b} = {4'd5, 4'd10};
      34: {tap_a, tap_b} = {4'd4, 4'd10};
      35: {tap_a, tap_b} = {4'd1, 4'd7};
      36: {tap_a, tap_b} = {4'd2, 4'd8};
      37: {tap_a, tap_b} = {4'd4, 4'd10};
      default: begin
        hit   = 1'b0;
        tap_a = 4'd1;
        tap_b = 4'd1;
      end
    endcase
  end
endmodule

// File: rtl/spc_barker.sv
module spc_barker #(
  parameter int PER_W = 16
) (
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] pos,
  output logic             chip
);
  import spc_pkg::*;

  logic        short_word;
  logic [12:0] word;
  logic [3:0]  len;

  // Both words are left-aligned so bit 12 is always the first chip
  assign short_word = (period == PER_W'(11));
  assign word       = short_word ? {BARKER11, 2'b00} : BARKER13;
  assign len        = short_word ? 4'd11 : 4'd13;

  always_comb begin
    chip = 1'b0;
    if (pos < PER_W'(len))
      chip = word[4'd12 - pos[3:0]];
  end
endmodule

// File: rtl/spc_code_gen.sv
module spc_code_gen #(
  parameter int POLY_W = 24,
  parameter int PER_W  = 16,
  parameter int SAT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [2:0]        code_type,
  input  logic [POLY_W-1:0] poly_a,
  input  logic [POLY_W-1:0] poly_b,
  input  logic [POLY_W-1:0] gold_offset,
  input  logic [SAT_W-1:0]  sat_id,
  input  logic [PER_W-1:0]  code_period,
  input  logic              chip_ready,
  output logic              chip_valid,
  output logic              chip_i,
  output logic              chip_q,
  output logic              sop
);
  import spc_pkg::*;

  localparam int NREG = 2;
  localparam logic [POLY_W-1:0] ONES = '1;

  code_t             ctype;
  logic [PER_W-1:0]  cnt;
  logic              last, accept, reload, advance;
  logic [POLY_W-1:0] lf_mask  [NREG];
  logic [POLY_W-1:0] lf_seed  [NREG];
  logic [POLY_W-1:0] lf_state [NREG];
  logic              lf_out   [NREG];
  logic              sat_hit, barker_chip, b_taps;
  logic [3:0]        tap_a, tap_b;
  logic              chip;

  assign ctype = code_t'(code_type);

  // Stream handshake and period position
  always_ff @(posedge clk) begin
    if (rst) chip_valid <= 1'b0;
    else     chip_valid <= 1'b1;
  end

  assign accept  = chip_valid & chip_ready & ~restart;
  assign last    = (cnt == code_period - PER_W'(1));
  assign reload  = rst | restart | (accept & last);
  assign advance = accept & ~last;

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (accept)
      cnt <= last ? '0 : cnt + PER_W'(1);
  end

  // Register configuration per code family
  always_comb begin
    if (ctype == CT_CA) begin
      lf_mask[0] = POLY_W'(CA_A_MASK);
      lf_mask[1] = POLY_W'(CA_B_MASK);
    end else begin
      lf_mask[0] = poly_a;
      lf_mask[1] = poly_b;
    end
    lf_seed[0] = ONES;
    lf_seed[1] = (ctype == CT_GOLD) ? (ONES ^ gold_offset) : ONES;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    spc_lfsr #(.W(POLY_W)) i_lfsr (
      .clk   (clk),
      .load  (reload),
      .step  (advance),
      .seed  (lf_seed[g]),
      .mask  (lf_mask[g]),
      .state (lf_state[g])
    );
    spc_tap_pick #(.W(POLY_W)) i_pick (
      .state   (lf_state[g]),
      .mask    (lf_mask[g]),
      .out_bit (lf_out[g])
    );
  end

  spc_sat_taps #(.SAT_W(SAT_W)) i_sat (
    .sat   (sat_id),
    .hit   (sat_hit),
    .tap_a (tap_a),
    .tap_b (tap_b)
  );

  assign b_taps = sat_hit & (lf_state[1][tap_a - 4'd1] ^ lf_state[1][tap_b - 4'd1]);

  spc_barker #(.PER_W(PER_W)) i_barker (
    .period (code_period),
    .pos    (cnt),
    .chip   (barker_chip)
  );

  always_comb begin
    case (ctype)
      CT_GOLD:   chip = lf_out[0] ^ lf_out[1];
      CT_MLS:    chip = lf_out[0];
      CT_BARKER: chip = barker_chip;
      CT_CA:     chip = lf_out[0] ^ b_taps;
      default:   chip = 1'b0;
    endcase
  end

  assign chip_i = chip;
  assign chip_q = chip;
  assign sop    = chip_valid & (cnt == '0);
endmodule

// File: rtl/spc_code_gen_chk.sv
module spc_code_gen_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             chip_ready,
  input logic             chip_valid,
  input logic             chip_i,
  input logic             chip_q,
  input logic             sop,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] code_period
);
  a_r9_iq_equal: assert property (@(posedge clk) disable iff (rst)
    chip_i == chip_q);

  a_r8_sop_needs_valid: assert property (@(posedge clk) disable iff (rst)
    sop |-> chip_valid);

  a_r10_restart_sop: assert property (@(posedge clk) disable iff (rst)
    restart |=> sop);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (chip_valid && !chip_ready && !restart) |=> $stable(cnt));

  a_r8_sop_one_chip: assert property (@(posedge clk) disable iff (rst)
    (chip_valid && chip_ready && sop && !restart && code_period > PER_W'(1)) |=> !sop);

  a_r1_valid_rises: assert property (@(posedge clk) disable iff (rst)
    !chip_valid |=> chip_valid);

  a_r1_valid_stays: assert property (@(posedge clk) disable iff (rst)
    chip_valid |=> chip_valid);
endmodule

bind spc_code_gen spc_code_gen_chk #(.PER_W(PER_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .restart     (restart),
  .chip_ready  (chip_ready),
  .chip_valid  (chip_valid),
  .chip_i      (chip_i),
  .chip_q      (chip_q),
  .sop         (sop),
  .cnt         (cnt),
  .code_period (code_period)
);

// File: tb/test_spc_code_gen.sv
`timescale 1ns/1ps
module test_spc_code_gen;
  logic        clk = 1'b0;
  logic        rst, restart, chip_ready;
  logic [2:0]  code_type;
  logic [23:0] poly_a, poly_b, gold_offset;
  logic [5:0]  sat_id;
  logic [15:0] code_period;
  logic        chip_valid, chip_i, chip_q, sop;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spc_code_gen i_spc_code_gen (
    .clk(clk), .rst(rst), .restart(restart), .code_type(code_type),
    .poly_a(poly_a), .poly_b(poly_b), .gold_offset(gold_offset),
    .sat_id(sat_id), .code_period(code_period), .chip_ready(chip_ready),
    .chip_valid(chip_valid), .chip_i(chip_i), .chip_q(chip_q), .sop(sop)
  );

  typedef struct packed {
    logic [2:0]  ctype;
    logic [23:0] pa;
    logic [23:0] pb;
    logic [23:0] off;
    logic [5:0]  sat;
    logic [15:0] per;
    logic [5:0]  n;
    logic [31:0] exp_bits;  // bit i = chip i
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 24'h000009, 24'h0, 24'h0,      6'd0,  16'd15,   6'd20, 32'h000789AF}, // R2 R3
    '{3'd2, 24'h000009, 24'h0, 24'h0,      6'd0,  16'd5,    6'd12, 32'h00000DEF}, // R3 truncation
    '{3'd3, 24'h0,      24'h0, 24'h0,      6'd0,  16'd11,   6'd13, 32'h000008ED}, // R5 11-chip
    '{3'd3, 24'h0,      24'h0, 24'h0,      6'd0,  16'd13,   6'd15, 32'h0000759F}, // R5 13-chip
    '{3'd3, 24'h0,      24'h0, 24'h0,      6'd0,  16'd14,   6'd15, 32'h0000559F}, // R5 zero past word
    '{3'd4, 24'hFFFFFF, 24'h123456, 24'hABC, 6'd1, 16'd1023, 6'd10, 32'h00000013}, // R6 sat 1
    '{3'd4, 24'h0,      24'h0, 24'h0,      6'd2,  16'd1023, 6'd10, 32'h00000027}, // R6 sat 2
    '{3'd4, 24'h0,      24'h0, 24'h0,      6'd0,  16'd1023, 6'd10, 32'h000003FF}, // R6 no satellite
    '{3'd5, 24'h000009, 24'h0, 24'h0,      6'd0,  16'd3,    6'd8,  32'h00000000}, // R11
    '{3'd2, 24'h000009, 24'h0, 24'h000005, 6'd0,  16'd15,   6'd15, 32'h000009AF}  // R4 offset unused
  };

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setup(input vec_t v);
    @(negedge clk);
    code_type = v.ctype; poly_a = v.pa; poly_b = v.pb; gold_offset = v.off;
    sat_id = v.sat; code_period = v.per;
    restart = 1'b1; chip_ready = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // Reads n chips with ready held high, starting at the current falling edge
  task automatic collect(input int n, input int per,
                         output logic [63:0] bits, output logic [63:0] sops, output bit iq_ok);
    bits = '0; sops = '0; iq_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      bits[i] = chip_i;
      sops[i] = sop;
      if (chip_q !== chip_i) iq_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] sop_pattern(input int n, input int per);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = ((i % per) == 0);
    return r;
  endfunction

  function automatic int top_bit(input logic [23:0] m);
    int t = 0;
    for (int k = 0; k < 24; k++) if (m[k]) t = k;
    return t;
  endfunction

  // Gold reference: XOR of two Fibonacci registers, reload at each period
  function automatic logic [63:0] gold_ref(input logic [23:0] ma, input logic [23:0] mb,
                                           input logic [23:0] off, input int per, input int n);
    logic [23:0] a = '1;
    logic [23:0] b = '1 ^ off;
    logic [63:0] r = '0;
    int ta = top_bit(ma);
    int tb = top_bit(mb);
    for (int i = 0; i < n; i++) begin
      r[i] = a[ta] ^ b[tb];
      if ((i % per) == per - 1) begin
        a = '1; b = '1 ^ off;
      end else begin
        a = {a[22:0], ^(a & ma)};
        b = {b[22:0], ^(b & mb)};
      end
    end
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] bits, sops, g0, g1;
    bit iq;
    vec_t v;
    rst = 1'b1; restart = 1'b0; chip_ready = 1'b0;
    code_type = 3'd2; poly_a = 24'h000009; poly_b = '0; gold_offset = '0;
    sat_id = '0; code_period = 16'd15;
    repeat (3) @(negedge clk);
    check(chip_valid == 1'b0, "R1 valid low in reset", 64'(chip_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(chip_valid == 1'b1 && sop == 1'b1 && chip_i == 1'b1, "R1 first chip after reset",
          {61'd0, chip_valid, sop, chip_i}, 64'd7);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      setup(v);
      collect(int'(v.n), int'(v.per), bits, sops, iq);
      check(bits == 64'(v.exp_bits), $sformatf("R2-R6 vector %0d chips", k), bits, 64'(v.exp_bits));
      check(sops == sop_pattern(int'(v.n), int'(v.per)), $sformatf("R8 vector %0d sop", k),
            sops, sop_pattern(int'(v.n), int'(v.per)));
      check(iq, "R9 chip_q equals chip_i", 64'(iq), 64'd1);
    end

    // R4 Gold codes against the bench model, two offsets
    v = '{3'd1, 24'h000012, 24'h00001B, 24'h0, 6'd0, 16'd31, 6'd40, 32'h0};
    setup(v);
    collect(40, 31, g0, sops, iq);
    check(g0 == gold_ref(24'h12, 24'h1B, 24'h0, 31, 40), "R4 Gold offset 0", g0,
          gold_ref(24'h12, 24'h1B, 24'h0, 31, 40));
    v.off = 24'h000005;
    setup(v);
    collect(40, 31, g1, sops, iq);
    check(g1 == gold_ref(24'h12, 24'h1B, 24'h5, 31, 40), "R4 Gold offset 5", g1,
          gold_ref(24'h12, 24'h1B, 24'h5, 31, 40));
    check(g0 != g1, "R4 offset changes code", g1, g0);

    // R7 back-pressure: stall on chip 0 and on chip 2
    v = VECS[0];
    setup(v);
    chip_ready = 1'b0;
    begin
      bit held = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (chip_i !== 1'b1 || sop !== 1'b1) held = 1'b0;
      end
      check(held, "R7 stall holds first chip and sop", {62'd0, chip_i, sop}, 64'd3);
    end
    chip_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chip_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(sop == 1'b0 && chip_i == 1'b1, "R7 stall holds chip 2", {62'd0, sop, chip_i}, 64'd1);
    chip_ready = 1'b1;
    collect(6, 15, bits, sops, iq);
    check(bits[5:0] == 6'b101011, "R7 chips 2..7 after stalls", bits, 64'b101011);

    // R10 restart mid-period, with ready high during the restart cycle
    repeat (3) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    collect(16, 15, bits, sops, iq);
    check(bits[15:0] == 16'h89AF && sops[15:0] == 16'h8001, "R10 restart realigns",
          {bits[15:0], sops[15:0]}, {16'h89AF, 16'h8001});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule